// File: doc/BRIEF.md
# Shadow-Register Delay Probe

This block adds delay characterisation to a bank of functional scan flip-flops. A second flip-flop, the shadow, sits beside each functional bit and samples the same data input on its own clock. That shadow clock has a controllable phase offset and is generated outside the block. A single XOR per bit compares the shadow value with the functional value. One extra multiplexer in front of each existing scan flip-flop can load that XOR result into the flop. The comparison outcome then leaves the chip on the normal scan chain, and no separate readout path is needed.

A sweep controller steps a phase-offset code upward from zero. Each step takes three cycles: a launch cycle that loads the old data and arms the shadow clock, a capture cycle in which the new data and the shadow edge arrive, and a compare cycle that loads the XOR results into the scan flops. A larger code places the shadow edge earlier before the functional edge. The first code that produces a mismatch on any bit is kept as the measured delay bin, and the controller then holds the scan flops so that the result can be shifted out. If no code fails, the controller reports a reserved all-ones value.

Top module: `delay_probe`

## Requirements
- R1: While reset is asserted and just after it, sweep_busy and sweep_done are 0, phase_code is 0, q_out is 0 and delay_bin is all ones.
- R2: While the controller is idle and scan_en is low, each clock edge loads d_in into the functional flops, so q_out equals the d_in of the previous cycle.
- R3: While scan_en is high, the flops shift at every edge and this overrides every other load. scan_in enters bit 0, bit i moves to bit i+1, and scan_out is bit WIDTH-1.
- R4: A sweep_start seen in the idle or done state begins a sweep at code 0. Each code occupies a launch cycle, a capture cycle and a compare cycle, in that order. shd_arm is high only during the launch cycle. After a compare with no mismatch, phase_code rises by exactly one.
- R5: At the end of the compare cycle, each functional flop loads the XOR of its own value and its shadow flop's value.
- R6: If any bit mismatches in a compare cycle, delay_bin takes that cycle's phase_code and sweep_done rises at the next edge. For a first failing code k, this is 3(k+1) edges after the start edge.
- R7: If the compare at the last code (2^CODE_W - 2) shows no mismatch, delay_bin is set to all ones, the no-failure value, and sweep_done rises. With CODE_W=3 this happens 21 edges after the start edge.
- R8: While sweep_done is high and scan_en is low, q_out holds the compare result and changes on d_in have no effect.
- R9: A sweep_start pulse during a running sweep has no effect: the running sweep's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shd_clk | input | 1 | Phase-shifted shadow clock, generated outside the block |
| d_in | input | WIDTH | Data inputs of the monitored paths |
| q_out | output | WIDTH | Functional / scan flop outputs |
| scan_en | input | 1 | Shift enable for the scan chain |
| scan_in | input | 1 | Serial scan input into bit 0 |
| scan_out | output | 1 | Serial scan output from bit WIDTH-1 |
| sweep_start | input | 1 | Starts a phase sweep when idle or done |
| shd_arm | output | 1 | High in the launch cycle; the shadow edge is due in the next cycle |
| phase_code | output | CODE_W | Current phase-offset code for the shadow clock generator |
| sweep_busy | output | 1 | A sweep is running |
| sweep_done | output | 1 | Sweep finished; result held |
| delay_bin | output | CODE_W | First failing code, or all ones if no code failed |

## Verification
On every cycle, the assertions check the per-flop multiplexer priorities: the shift path, the XOR load in the compare cycle and the hold once the sweep is done. They also check the controller's stepping, which covers the fixed launch-capture-compare order, the single-step code increment, how the result is latched on a failure and how it saturates at the last code. Only the bench's scenarios show that the measured bin matches the data arrival time. Those scenarios use a shadow clock model in which each code moves the shadow edge one step earlier. The same holds for the XOR pattern that appears on the scan chain, and for the case where the old and new data are equal and no code ever fails.

// File: rtl/dprobe_pkg.sv
`timescale 1ns/1ps
package dprobe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LAUNCH  = 3'd1,
      ST_CAPTURE = 3'd2,
      ST_COMPARE = 3'd3,
      ST_DONE    = 3'd4
   } sweep_state_t;

endpackage

// File: rtl/probe_cell.sv
`timescale 1ns/1ps
module probe_cell (
   input  logic clk,
   input  logic shd_clk,
   input  logic rst_n,
   input  logic d,
   input  logic scan_en,
   input  logic scan_si,
   input  logic cmp_load,
   input  logic hold,
   output logic q,
   output logic mis
);

   logic shd_q;

   // shadow flop: same data, separate phase-shifted clock
   always_ff @(posedge shd_clk or negedge rst_n) begin
      if (!rst_n) shd_q <= 1'b0;
      else        shd_q <= d;
   end

   // single-gate comparator
   assign mis = q ^ shd_q;

   // existing scan flop with the added result multiplexer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (scan_en)  q <= scan_si;
      else if (cmp_load) q <= mis;
      else if (!hold)    q <= d;
   end

   // R3
   scan_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> q == $past(scan_si));

   // R5
   cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_load && !scan_en) |=> q == ($past(q) ^ $past(shd_q)));

   // R8
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !scan_en && !cmp_load) |=> $stable(q));

endmodule

// File: rtl/probe_chain.sv
`timescale 1ns/1ps
module probe_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             shd_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             scan_en,
   input  logic             scan_in,
   input  logic             cmp_load,
   input  logic             hold,
   output logic [WIDTH-1:0] q,
   output logic             scan_out,
   output logic             mismatch_any
);

   logic [WIDTH:0]   chain;
   logic [WIDTH-1:0] mis_vec;

   assign chain[0] = scan_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      probe_cell u_cell (
         .clk      (clk),
         .shd_clk  (shd_clk),
         .rst_n    (rst_n),
         .d        (d[i]),
         .scan_en  (scan_en),
         .scan_si  (chain[i]),
         .cmp_load (cmp_load),
         .hold     (hold),
         .q        (q[i]),
         .mis      (mis_vec[i])
      );
      assign chain[i+1] = q[i];
   end

   assign scan_out     = chain[WIDTH];
   assign mismatch_any = |mis_vec;

endmodule

// File: rtl/sweep_ctrl.sv
`timescale 1ns/1ps
module sweep_ctrl
   import dprobe_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mismatch_any,
   output logic [CODE_W-1:0] phase_code,
   output logic [CODE_W-1:0] delay_bin,
   output logic              shd_arm,
   output logic              cmp_load,
   output logic              hold,
   output logic              busy,
   output logic              done
);

   localparam logic [CODE_W-1:0] NO_FAIL   = '1;
   localparam logic [CODE_W-1:0] LAST_CODE = {{(CODE_W-1){1'b1}}, 1'b0};

   sweep_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase_code <= '0;
         delay_bin  <= NO_FAIL;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state      <= ST_LAUNCH;
                  phase_code <= '0;
                  delay_bin  <= NO_FAIL;
               end
            end
            ST_LAUNCH:  state <= ST_CAPTURE;
            ST_CAPTURE: state <= ST_COMPARE;
            ST_COMPARE: begin
               if (mismatch_any) begin
                  delay_bin <= phase_code;
                  state     <= ST_DONE;
               end else if (phase_code == LAST_CODE) begin
                  delay_bin <= NO_FAIL;
                  state     <= ST_DONE;
               end else begin
                  phase_code <= phase_code + CODE_W'(1);
                  state      <= ST_LAUNCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign shd_arm  = (state == ST_LAUNCH);
   assign cmp_load = (state == ST_COMPARE);
   assign hold     = (state == ST_DONE);
   assign done     = (state == ST_DONE);
   assign busy     = (state == ST_LAUNCH) || (state == ST_CAPTURE) || (state == ST_COMPARE);

   // R4
   code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_load && !mismatch_any && phase_code != LAST_CODE)
      |=> (shd_arm && phase_code == $past(phase_code) + CODE_W'(1)));

   // R4
   arm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shd_arm |=> (!shd_arm && busy) ##1 cmp_load);

   // R4
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> phase_code <= LAST_CODE);

   // R6
   fail_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_load && mismatch_any) |=> (done && delay_bin == $past(phase_code)));

   // R7
   no_fail_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_load && !mismatch_any && phase_code == LAST_CODE)
      |=> (done && delay_bin == NO_FAIL));

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cmp_load) |=> (busy && $stable(phase_code)));

endmodule

// File: rtl/delay_probe.sv
`timescale 1ns/1ps
module delay_probe #(
   parameter int WIDTH  = 8,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shd_clk,
   input  logic [WIDTH-1:0]  d_in,
   output logic [WIDTH-1:0]  q_out,
   input  logic              scan_en,
   input  logic              scan_in,
   output logic              scan_out,
   input  logic              sweep_start,
   output logic              shd_arm,
   output logic [CODE_W-1:0] phase_code,
   output logic              sweep_busy,
   output logic              sweep_done,
   output logic [CODE_W-1:0] delay_bin
);

   if (WIDTH < 1) begin : g_bad_width
      $error("delay_probe: WIDTH must be at least 1");
   end
   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code
      $error("delay_probe: CODE_W must lie in 2..16");
   end

   logic cmp_load;
   logic hold;
   logic mismatch_any;

   probe_chain #(.WIDTH(WIDTH)) u_chain (
      .clk          (clk),
      .shd_clk      (shd_clk),
      .rst_n        (rst_n),
      .d            (d_in),
      .scan_en      (scan_en),
      .scan_in      (scan_in),
      .cmp_load     (cmp_load),
      .hold         (hold),
      .q            (q_out),
      .scan_out     (scan_out),
      .mismatch_any (mismatch_any)
   );

   sweep_ctrl #(.CODE_W(CODE_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (sweep_start),
      .mismatch_any (mismatch_any),
      .phase_code   (phase_code),
      .delay_bin    (delay_bin),
      .shd_arm      (shd_arm),
      .cmp_load     (cmp_load),
      .hold         (hold),
      .busy         (sweep_busy),
      .done         (sweep_done)
   );

endmodule

// File: tb/delay_probe_test.sv
`timescale 1ns/1ps
module delay_probe_test;

   localparam int W  = 8;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          shd_clk = 1'b0;
   logic [W-1:0]  d_in = '0;
   logic [W-1:0]  q_out;
   logic          scan_en = 1'b0;
   logic          scan_in = 1'b0;
   logic          scan_out;
   logic          sweep_start = 1'b0;
   logic          shd_arm;
   logic [CW-1:0] phase_code;
   logic          sweep_busy;
   logic          sweep_done;
   logic [CW-1:0] delay_bin;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  model_on = 1'b0;
   logic [W-1:0] m_v0 = '0;
   logic [W-1:0] m_v1 = '0;
   real arr_ns = 0.0;

   always #4 clk = ~clk;

   delay_probe #(.WIDTH(W), .CODE_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .shd_clk(shd_clk), .d_in(d_in), .q_out(q_out),
      .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
      .sweep_start(sweep_start), .shd_arm(shd_arm), .phase_code(phase_code),
      .sweep_busy(sweep_busy), .sweep_done(sweep_done), .delay_bin(delay_bin)
   );

   // path model: new data arrives arr_ns after the capture-cycle edge
   always @(negedge clk) begin
      if (model_on && shd_arm) begin
         #(4.0 + arr_ns) d_in = m_v1;
         #(8.5 - arr_ns) d_in = m_v0;
      end
   end

   // shadow clock model: code k puts the edge (0.5 + k) ns before the functional edge
   always @(negedge clk) begin
      if (model_on && shd_arm) begin
         #(4.0 + 7.5 - real'(phase_code)) shd_clk = 1'b1;
         #0.4 shd_clk = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_bin(input logic [W-1:0] a, input logic [W-1:0] b, input int arr_t);
      if (a == b) return 7;
      for (int k = 0; k < 7; k++)
         if (75 - 10*k < arr_t) return k;
      return 7;
   endfunction

   task automatic run_sweep(input logic [W-1:0] a, input logic [W-1:0] b, input int arr_t,
                            input bit extra_start, input string tag);
      int cnt;
      int eb;
      logic [W-1:0] ep;
      eb = exp_bin(a, b, arr_t);
      ep = (eb == 7) ? '0 : (a ^ b);
      m_v0 = a; m_v1 = b; arr_ns = real'(arr_t) / 10.0;
      d_in = a;
      model_on = 1'b1;
      @(negedge clk) sweep_start = 1'b1;
      @(negedge clk) sweep_start = 1'b0;
      chk(sweep_busy === 1'b1 && phase_code === '0, {tag, " R4 busy at code 0"},
          {31'd0, sweep_busy}, 32'd1);
      cnt = 0;
      while (!sweep_done && cnt < 100) begin
         sweep_start = (extra_start && cnt == 4);
         @(negedge clk);
         cnt++;
      end
      sweep_start = 1'b0;
      model_on = 1'b0;
      if (eb == 7) chk(delay_bin === 3'd7, {tag, " R7 no-fail code"}, delay_bin, eb);
      else         chk(delay_bin === CW'(eb), {tag, " R6 first failing code"}, delay_bin, eb);
      chk(cnt == 3*(eb < 7 ? eb + 1 : 7), {tag, " R4 sweep length"}, cnt, 3*(eb < 7 ? eb + 1 : 7));
      chk(q_out === ep, {tag, " R5 compare pattern"}, q_out, ep);
   endtask

   // {old data, new data, arrival time in 0.1 ns}
   localparam logic [23:0] VEC [0:6] = '{
      24'hA5_5A_4F, 24'h0F_F0_48, 24'h00_FF_34, 24'h3C_C3_1E,
      24'h81_01_12, 24'h55_AA_0A, 24'h77_77_4F
   };

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] pat;
      logic [W-1:0] sin;
      // R1 reset state
      repeat (2) @(negedge clk);
      chk(sweep_busy === 1'b0 && sweep_done === 1'b0, "R1 busy/done in reset", {sweep_busy, sweep_done}, 0);
      chk(delay_bin === 3'd7 && phase_code === 3'd0, "R1 codes in reset", {delay_bin, phase_code}, 32'h38);
      chk(q_out === '0, "R1 q_out in reset", q_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(q_out === '0 && !sweep_busy, "R1 after release", q_out, 0);

      // R2 functional capture while idle
      for (int i = 0; i < 3; i++) begin
         logic [W-1:0] v;
         v = W'(8'h3B * (i + 1));
         d_in = v;
         @(negedge clk);
         chk(q_out === v, "R2 functional load", q_out, v);
      end

      // R4 R5 R6 R7 table-driven sweeps
      for (int i = 0; i < 7; i++)
         run_sweep(VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]), 1'b0, $sformatf("vec%0d", i));

      // R9 start pulse mid-sweep ignored (first fail at code 3)
      run_sweep(8'h12, 8'h34, 52, 1'b1, "R9 mid-sweep start");

      // R8 hold while done, d_in ignored
      pat = 8'h12 ^ 8'h34;
      d_in = 8'hC9;
      repeat (3) @(negedge clk);
      chk(q_out === pat && sweep_done === 1'b1, "R8 hold while done", q_out, pat);

      // R3 scan out the result, scan in a new pattern
      sin = 8'hB4;
      scan_en = 1'b1;
      for (int k = 0; k < W; k++) begin
         chk(scan_out === pat[W-1-k], "R3 scan out bit", scan_out, pat[W-1-k]);
         scan_in = sin[W-1-k];
         @(negedge clk);
      end
      scan_en = 1'b0;
      chk(q_out === sin, "R3 scan in pattern", q_out, sin);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule